// File: doc/BRIEF.md
# Masked Local Bus Interrupt Controller

This block gathers up to sixteen level-sensitive interrupt requests from local peripherals and drives a single combined request to the processor. Each request line is sampled into a source register on every clock, so a source bit stays set only while its line is held high. A software-writable enable mask selects which sources may reach the combined output.

Software reaches the block through a small register port with 16-bit registers. Offset 0 is read-only and returns an encoded vector that identifies the lowest-numbered enabled pending source. Offset 2 holds the enable mask. Byte accesses are merged into the 16-bit word by read-modify-write. A 32-bit access is treated as two 16-bit accesses: the low half goes to the given address and the high half to the address plus two. Read data is registered and stays on its output until the next read.

Top module: `irqc_lbus_ctrl`

## Requirements
- R1: Each source bit takes the level of its request line at every clock edge. A line that goes high or low changes the source bit one clock later, and the source register keeps no memory of earlier pulses.
- R2: `irq_out` is high exactly when the bitwise AND of source and mask is nonzero.
- R3: A read at offset 0 returns 0 when nothing is pending. Otherwise it returns (n+1)*4 in bits 15:0, where n is the lowest-numbered pending bit; bits 1:0 are always 0.
- R4: A 16-bit write to offset 2 loads the enable mask, and a 16-bit read there returns it. `irq_out` reflects a new mask from the clock edge that accepts the write.
- R5: Reset clears the source register, the mask and the read data register, and drives `irq_out` low. Reset asserts asynchronously and releases two clocks after `rst_n` rises.
- R6: A byte write (`acc_size`=0) changes only the addressed byte of the 16-bit word at address with bit 0 cleared: address bit 0 = 0 selects bits 7:0 and 1 selects bits 15:8. The other byte keeps its current value.
- R7: A byte read returns the addressed byte of that 16-bit word in `rd_data` bits 7:0, with bits 31:8 zero.
- R8: A 32-bit access (`acc_size`=2) at address A acts on the 16-bit word at A through data bits 15:0 and on the word at (A+2) mod 4096 through data bits 31:16. A 16-bit access uses `acc_size`=1.
- R9: Reads of any 16-bit word other than offsets 0 and 2, including words at odd addresses, return zero. Writes to offset 0, to unmapped words, or with `acc_size`=3 change nothing. Reads have no side effect.
- R10: Read data appears on `rd_data` at the clock edge that accepts the read and holds until the next read. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Level-sensitive request lines, bit i is source i |
| acc_valid | input | 1 | Register access request for this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 no access |
| acc_addr | input | 12 | Byte address within the register window |
| acc_wdata | input | 32 | Write data, right-aligned to the access size |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the request lines are synchronous to `clk` and that no access is presented while reset is active. The property tying the source register to the previous line levels is armed only after the first clock out of reset. The bench changes lines and access signals only on falling edges, and it issues accesses only after the synchronised reset has released. Every access takes one cycle and is followed by an idle cycle, so each check sees exactly one register update.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_NONE = 2'd3
  } acc_size_e;

  localparam int unsigned REG_W  = 16;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned OFS_VEC  = 0;
  localparam int unsigned OFS_MASK = 2;

endpackage

// File: rtl/irqc_src_capture.sv
module irqc_src_capture #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] src_o
);

  logic [N-1:0] src_d;
  logic [N-1:0] src_q;

  always_comb begin
    src_d = lines_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else begin
      src_q <= src_d;
    end
  end

  assign src_o = src_q;

endmodule

// File: rtl/irqc_lowest_enc.sv
module irqc_lowest_enc #(
  parameter int unsigned N   = 16,
  parameter int unsigned VW  = 16
) (
  input  logic [N-1:0]  pend_i,
  output logic [VW-1:0] vec_o
);

  logic [N-1:0] lowest;
  logic [N-1:0] below_any;

  generate
    for (genvar g = 0; g < N; g++) begin : g_iso
      if (g == 0) begin : g_first
        assign below_any[g] = 1'b0;
      end else begin : g_rest
        assign below_any[g] = below_any[g-1] | pend_i[g-1];
      end
      assign lowest[g] = pend_i[g] & ~below_any[g];
    end
  endgenerate

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N; i++) begin
      if (lowest[i]) begin
        vec_o = vec_o | VW'((i + 1) << 2);
      end
    end
  end

endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  acc_size_e        acc_size,
  input  logic [AW-1:0]    acc_addr,
  input  logic [BUS_W-1:0] acc_wdata,
  input  logic [REG_W-1:0] vec_i,
  output logic [N-1:0]     mask_o,
  output logic [BUS_W-1:0] rd_data_o
);

  localparam logic [AW-1:0] A_VEC  = AW'(OFS_VEC);
  localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_STEP = AW'(2);

  logic [N-1:0]     mask_q;
  logic [N-1:0]     mask_d;
  logic             mask_en;
  logic [REG_W-1:0] mask16;
  logic [REG_W-1:0] mask_new16;
  logic [BUS_W-1:0] rd_q;
  logic [BUS_W-1:0] rd_d;
  logic             rd_en;
  logic [AW-1:0]    a_lo;
  logic [AW-1:0]    a_hi;
  logic [AW-1:0]    a_even;
  logic [REG_W-1:0] h_even;
  logic [REG_W-1:0] h_lo;
  logic [REG_W-1:0] h_hi;

  function automatic logic [REG_W-1:0] word_at(
    input logic [AW-1:0]    a,
    input logic [REG_W-1:0] vec,
    input logic [REG_W-1:0] msk
  );
    logic [REG_W-1:0] r;
    if (a == A_VEC) begin
      r = vec;
    end else if (a == A_MASK) begin
      r = msk;
    end else begin
      r = '0;
    end
    return r;
  endfunction

  assign mask16 = REG_W'(mask_q);
  assign a_lo   = acc_addr;
  assign a_hi   = acc_addr + A_STEP;
  assign a_even = {acc_addr[AW-1:1], 1'b0};

  assign h_even = word_at(a_even, vec_i, mask16);
  assign h_lo   = word_at(a_lo, vec_i, mask16);
  assign h_hi   = word_at(a_hi, vec_i, mask16);

  // read path: assemble the response from 16-bit word reads
  always_comb begin
    rd_en = acc_valid & ~acc_write;
    rd_d  = rd_q;
    if (rd_en) begin
      unique case (acc_size)
        ACC_BYTE: rd_d = acc_addr[0] ? BUS_W'(h_even[15:8]) : BUS_W'(h_even[7:0]);
        ACC_HALF: rd_d = BUS_W'(h_lo);
        ACC_WORD: rd_d = {h_hi, h_lo};
        default:  rd_d = '0;
      endcase
    end
  end

  // write path: merge narrow writes into the current mask word
  always_comb begin
    mask_en    = 1'b0;
    mask_new16 = mask16;
    if (acc_valid && acc_write) begin
      unique case (acc_size)
        ACC_BYTE: begin
          if (a_even == A_MASK) begin
            mask_en    = 1'b1;
            mask_new16 = acc_addr[0] ? {acc_wdata[7:0], mask16[7:0]}
                                     : {mask16[15:8], acc_wdata[7:0]};
          end
        end
        ACC_HALF: begin
          if (a_lo == A_MASK) begin
            mask_en    = 1'b1;
            mask_new16 = acc_wdata[15:0];
          end
        end
        ACC_WORD: begin
          if (a_lo == A_MASK) begin
            mask_en    = 1'b1;
            mask_new16 = acc_wdata[15:0];
          end else if (a_hi == A_MASK) begin
            mask_en    = 1'b1;
            mask_new16 = acc_wdata[31:16];
          end
        end
        default: begin
          mask_en    = 1'b0;
          mask_new16 = mask16;
        end
      endcase
    end
    mask_d = mask_new16[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign mask_o    = mask_q;
  assign rd_data_o = rd_q;

endmodule

// File: rtl/irqc_lbus_ctrl.sv
module irqc_lbus_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_lines,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [1:0]       acc_size,
  input  logic [AW-1:0]    acc_addr,
  input  logic [BUS_W-1:0] acc_wdata,
  output logic [BUS_W-1:0] rd_data,
  output logic             irq_out
);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [N-1:0]     src_q;
  logic [N-1:0]     mask_q;
  logic [N-1:0]     pend;
  logic [REG_W-1:0] vec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  irqc_src_capture #(.N(N)) u_src (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lines_i (irq_lines),
    .src_o   (src_q)
  );

  assign pend = src_q & mask_q;

  irqc_lowest_enc #(.N(N), .VW(REG_W)) u_enc (
    .pend_i (pend),
    .vec_o  (vec)
  );

  irqc_regport #(.N(N), .AW(AW)) u_port (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size_e'(acc_size)),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .vec_i     (vec),
    .mask_o    (mask_q),
    .rd_data_o (rd_data)
  );

  assign irq_out = |pend;

endmodule

// File: rtl/irqc_lbus_ctrl_chk.sv
module irqc_lbus_ctrl_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_lines,
  input logic [N-1:0] src,
  input logic [N-1:0] mask,
  input logic [15:0]  vec,
  input logic         irq_out,
  input logic         acc_valid,
  input logic         acc_write,
  input logic [31:0]  rd_data
);

  logic         armed;
  logic [4:0]   idx;
  logic [N-1:0] pend;
  logic [N-1:0] below;
  logic         lowest_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    pend      = src & mask;
    idx       = 5'(vec[15:2]) - 5'd1;
    below     = ({{(N-1){1'b0}}, 1'b1} << idx) - {{(N-1){1'b0}}, 1'b1};
    lowest_ok = pend[idx[$clog2(N)-1:0]] && ((pend & below) == '0);
  end

  AST_SRC_TRACKS_LINES: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    src == $past(irq_lines)); // R1

  AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (vec != 16'd0)); // R2

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (vec[1:0] == 2'b00) && (vec <= 16'(N * 4))); // R3

  AST_VEC_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != 16'd0) |-> lowest_ok); // R3

  AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |=> $stable(mask)); // R9

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> $stable(rd_data)); // R10

endmodule

bind irqc_lbus_ctrl irqc_lbus_ctrl_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_lines (irq_lines),
  .src       (src_q),
  .mask      (mask_q),
  .vec       (vec),
  .irq_out   (irq_out),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .rd_data   (rd_data)
);

// File: tb/sim_irqc_lbus_ctrl.sv
`timescale 1ns/1ps
module sim_irqc_lbus_ctrl;

  logic        clk;
  logic        rst_n;
  logic [15:0] irq_lines;
  logic        acc_valid;
  logic        acc_write;
  logic [1:0]  acc_size;
  logic [11:0] acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] rd_data;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  logic [31:0] d;

  irqc_lbus_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .rd_data   (rd_data),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {mask, lines, expected vector, expected irq}
  localparam logic [48:0] TABLE [10] = '{
    {16'hFFFF, 16'h0000, 16'h0000, 1'b0},
    {16'hFFFF, 16'h0001, 16'h0004, 1'b1},
    {16'hFFFF, 16'h8000, 16'h0040, 1'b1},
    {16'hFFFF, 16'h00F0, 16'h0014, 1'b1},
    {16'h0F00, 16'h00F0, 16'h0000, 1'b0},
    {16'h0F00, 16'h0FF0, 16'h0024, 1'b1},
    {16'hFFFE, 16'h0003, 16'h0008, 1'b1},
    {16'h8000, 16'hFFFF, 16'h0040, 1'b1},
    {16'h0000, 16'hFFFF, 16'h0000, 1'b0},
    {16'h0010, 16'h0010, 16'h0014, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] v);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = v;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] v);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
    @(negedge clk);
    acc_valid = 1'b0;
    v = rd_data;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_lines = '0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_size = 2'd1; acc_addr = '0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 reset state
    check("R5 irq after reset", 32'(irq_out), 32'h0);
    check("R5 rd_data after reset", rd_data, 32'h0);
    rd(12'h002, 2'd1, d); check("R5 mask after reset", d, 32'h0);

    // R1 R2 R3 table walk
    for (int i = 0; i < 10; i++) begin
      wr(12'h002, 2'd1, 32'(TABLE[i][48:33]));
      set_lines(TABLE[i][32:17]);
      check($sformatf("R2 irq row %0d", i), 32'(irq_out), 32'(TABLE[i][0]));
      rd(12'h000, 2'd1, d);
      check($sformatf("R3 vector row %0d", i), d, 32'(TABLE[i][16:1]));
    end

    // R4 mask readback and immediate effect on the output
    set_lines(16'h0001);
    wr(12'h002, 2'd1, 32'h0000);
    check("R4 irq off with mask 0", 32'(irq_out), 32'h0);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 12'h002; acc_size = 2'd1; acc_wdata = 32'h0001;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    check("R4 irq one cycle after mask write", 32'(irq_out), 32'h1);
    wr(12'h002, 2'd1, 32'h1234);
    rd(12'h002, 2'd1, d); check("R4 mask readback", d, 32'h1234);

    // R1 line drop clears the source
    set_lines(16'h0000);
    check("R1 irq after line drop", 32'(irq_out), 32'h0);

    // R6 byte writes merge
    wr(12'h003, 2'd0, 32'h000000AB);
    rd(12'h002, 2'd1, d); check("R6 high byte write", d, 32'h0000AB34);
    wr(12'h002, 2'd0, 32'h000000CD);
    rd(12'h002, 2'd1, d); check("R6 low byte write", d, 32'h0000ABCD);

    // R7 byte reads
    rd(12'h003, 2'd0, d); check("R7 byte read mask high", d, 32'h000000AB);
    rd(12'h002, 2'd0, d); check("R7 byte read mask low", d, 32'h000000CD);
    set_lines(16'h0008);
    rd(12'h000, 2'd0, d); check("R7 byte read vector low", d, 32'h00000010);
    rd(12'h001, 2'd0, d); check("R7 byte read vector high", d, 32'h00000000);

    // R8 32-bit accesses
    rd(12'h000, 2'd2, d); check("R8 word read at 0", d, 32'hABCD0010);
    wr(12'h000, 2'd2, 32'h5555_0000);
    rd(12'h002, 2'd1, d); check("R8 word write at 0 upper half", d, 32'h00005555);
    wr(12'h002, 2'd2, 32'hEEEE_0F0F);
    rd(12'h002, 2'd2, d); check("R8 word read at 2", d, 32'h00000F0F);
    rd(12'hFFE, 2'd2, d); check("R8 word read wraps to 0", d, 32'h00100000);

    // R9 ignored writes and unmapped reads
    wr(12'h000, 2'd1, 32'hFFFF);
    wr(12'h006, 2'd1, 32'hFFFF);
    wr(12'h002, 2'd3, 32'hFFFF);
    rd(12'h002, 2'd1, d); check("R9 mask unchanged by ignored writes", d, 32'h00000F0F);
    rd(12'h000, 2'd1, d); check("R9 vector unchanged by write at 0", d, 32'h00000010);
    rd(12'h010, 2'd1, d); check("R9 unmapped read", d, 32'h0);
    rd(12'h001, 2'd1, d); check("R9 odd half read", d, 32'h0);

    // R10 read data held across writes
    rd(12'h002, 2'd1, d);
    wr(12'h002, 2'd1, 32'h00FF);
    check("R10 rd_data held after write", rd_data, 32'h00000F0F);

    // R5 reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R5 irq in reset", 32'(irq_out), 32'h0);
    check("R5 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(12'h002, 2'd1, d); check("R5 mask cleared by reset", d, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule